// File: doc/BRIEF.md
# Error-Position Search and Bit Correction over GF(16)

This block finishes decoding a length-15 binary cyclic code once an error-locator polynomial has been computed. It accepts the locator coefficients (degree up to three) together with the received 15-bit word. It then tests each of the 15 nonzero field elements as a possible root, one per clock. Every root marks one bit of the word as wrong, and those bits are inverted. The field is GF(2^4) built on the primitive polynomial x^4 + x + 1.

The polynomial is not evaluated from scratch at each point. Each coefficient sits in its own register, and on every step that register is multiplied by a fixed field constant. The XOR of all registers is then the polynomial's value at the next point. If the number of roots found differs from the polynomial's degree, the locator cannot be trusted. In that case the block raises a failure flag and returns the received word untouched.

A search starts with a one-cycle start strobe and finishes with a one-cycle done pulse. The results stay on the outputs until the next search ends.

Top module: `chien_locator`

## Requirements
- R1: While reset is low, and after it is released until the first search ends, done, fail, errMask, errCount and corrWord are all zero.
- R2: When start is high at a rising edge with no search running, done is high for exactly the one cycle that follows the 16th rising edge after that one.
- R3: Coefficient i of the locator is lambda[4i+3:4i], where i=0 is the constant term. Field elements are 4-bit polynomial-basis values, with alpha = 4'b0010 and the reduction polynomial x^4+x+1. Bit p of errMask (p = 0..14) is set exactly when the locator evaluates to zero at alpha^(-p).
- R4: When fail is low, corrWord equals the received word captured at start XOR errMask. For a locator built from real error positions, this restores the original word.
- R5: errCount equals the number of set bits in errMask.
- R6: The degree is the highest i in 1..3 with a nonzero coefficient, or 0 if there is none. fail is high exactly when errCount differs from that degree. When fail is high, corrWord equals the captured received word.
- R7: A start pulse that arrives while a search is running is ignored. The running search keeps its timing, and its results come from its own inputs.
- R8: corrWord, errMask, errCount and fail change only at the edge that raises done. They hold their values in every other cycle.
- R9: The constant coefficient takes part in every evaluation, so multiplying all coefficients by one nonzero constant leaves errMask, errCount and fail unchanged.
- R10: rxWord and lambda are captured at the accepted start. Changing them during a search has no effect on that search's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a search |
| lambda | input | 16 | Locator coefficients, 4 bits each, constant term in the low nibble |
| rxWord | input | 15 | Received word; bit p is codeword position p |
| corrWord | output | 15 | Corrected word, or the received word when fail is high |
| errMask | output | 15 | Positions found as roots |
| errCount | output | 4 | Number of roots found |
| fail | output | 1 | Root count differs from the locator degree |
| done | output | 1 | One-cycle pulse when results are updated |

## Verification
Suppose a term register is loaded or stepped with the wrong constant. The mask then shows wrong positions in the very next done pulse, and a count that no longer matches the degree usually raises fail as well. A wrong step counter or a wrong control state moves the done pulse away from the 16th edge, or stretches it, and this is visible on the first search. A wrong captured word or degree shows up in corrWord or fail on that same search. Each of these faults is exposed within about 17 cycles of a start.

// File: rtl/chien_pkg.sv
package chien_pkg;
  localparam int M = 4;
  localparam logic [M:0] PRIM = 5'b10011;
  localparam int N = (1 << M) - 1;
  localparam int CNT_W = $clog2(N + 1);

  typedef logic [M-1:0] gf_t;

  typedef enum logic [1:0] {S_IDLE, S_SEARCH, S_FINISH} state_t;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } ctrlStb_t;

  // multiply by alpha
  function automatic gf_t gfXtime(gf_t a);
    gf_t r;
    r = {a[M-2:0], 1'b0};
    if (a[M-1]) r = r ^ PRIM[M-1:0];
    return r;
  endfunction

  function automatic gf_t gfMul(gf_t a, gf_t b);
    gf_t acc;
    gf_t sh;
    acc = '0;
    sh = a;
    for (int k = 0; k < M; k++) begin
      if (b[k]) acc = acc ^ sh;
      sh = gfXtime(sh);
    end
    return acc;
  endfunction

  // alpha^e for 0 <= e < N
  function automatic gf_t gfPow(int unsigned e);
    gf_t r;
    r = gf_t'(1);
    for (int k = 0; k < N; k++) begin
      if (k < int'(e)) r = gfXtime(r);
    end
    return r;
  endfunction
endpackage

// File: rtl/chien_ctrl.sv
module chien_ctrl
  import chien_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  output ctrlStb_t         stb,
  output logic [CNT_W-1:0] stepIdx,
  output logic             busy
);
  state_t state;
  logic [CNT_W-1:0] stepCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepCnt <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_SEARCH;
            stepCnt <= '0;
          end
        end
        S_SEARCH: begin
          stepCnt <= stepCnt + CNT_W'(1);
          if (stepCnt == CNT_W'(N - 1)) state <= S_FINISH;
        end
        S_FINISH: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.load   = (state == S_IDLE) && start;
    stb.step   = (state == S_SEARCH);
    stb.finish = (state == S_FINISH);
    busy       = (state != S_IDLE);
    stepIdx    = stepCnt;
  end
endmodule

// File: rtl/chien_dp.sv
module chien_dp
  import chien_pkg::*;
#(
  parameter int T = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStb_t           stb,
  input  logic [CNT_W-1:0]   stepIdx,
  input  logic [(T+1)*M-1:0] lambda,
  input  logic [N-1:0]       rxWord,
  output logic [N-1:0]       corrWord,
  output logic [N-1:0]       errMask,
  output logic [CNT_W-1:0]   errCount,
  output logic               fail,
  output logic               done,
  output logic [N-1:0]       heldWord
);
  gf_t termVec [T+1];

  // one term register per coefficient, each stepped by its own constant alpha^(-i)
  for (genvar i = 0; i <= T; i++) begin : gTerm
    localparam gf_t STEP_C = gfPow((N - i) % N);
    gf_t termQ;
    always_ff @(posedge clk) begin
      if (!rstN)         termQ <= '0;
      else if (stb.load) termQ <= lambda[i*M +: M];
      else if (stb.step) termQ <= gfMul(termQ, STEP_C);
    end
    assign termVec[i] = termQ;
  end

  gf_t sumVal;
  logic isRoot;
  always_comb begin
    sumVal = '0;
    for (int i = 0; i <= T; i++) sumVal = sumVal ^ termVec[i];
    isRoot = (sumVal == '0);
  end

  logic [CNT_W-1:0] degIn;
  always_comb begin
    degIn = '0;
    for (int i = 1; i <= T; i++) begin
      if (lambda[i*M +: M] != '0) degIn = CNT_W'(i);
    end
  end

  logic [N-1:0]     wordQ;
  logic [N-1:0]     maskQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] degQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordQ <= '0;
      maskQ <= '0;
      cntQ  <= '0;
      degQ  <= '0;
    end else if (stb.load) begin
      wordQ <= rxWord;
      maskQ <= '0;
      cntQ  <= '0;
      degQ  <= degIn;
    end else if (stb.step && isRoot) begin
      maskQ[stepIdx] <= 1'b1;
      cntQ           <= cntQ + CNT_W'(1);
    end
  end

  logic mismatch;
  assign mismatch = (cntQ != degQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      corrWord <= '0;
      errMask  <= '0;
      errCount <= '0;
      fail     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= stb.finish;
      if (stb.finish) begin
        errMask  <= maskQ;
        errCount <= cntQ;
        fail     <= mismatch;
        corrWord <= mismatch ? wordQ : (wordQ ^ maskQ);
      end
    end
  end

  assign heldWord = wordQ;
endmodule

// File: rtl/chien_locator.sv
module chien_locator
  import chien_pkg::*;
#(
  parameter int T = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [(T+1)*M-1:0] lambda,
  input  logic [N-1:0]       rxWord,
  output logic [N-1:0]       corrWord,
  output logic [N-1:0]       errMask,
  output logic [CNT_W-1:0]   errCount,
  output logic               fail,
  output logic               done
);
  ctrlStb_t         stb;
  logic [CNT_W-1:0] stepIdx;
  logic             busy;
  logic [N-1:0]     heldWord;

  chien_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .stb     (stb),
    .stepIdx (stepIdx),
    .busy    (busy)
  );

  chien_dp #(.T(T)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .stepIdx  (stepIdx),
    .lambda   (lambda),
    .rxWord   (rxWord),
    .corrWord (corrWord),
    .errMask  (errMask),
    .errCount (errCount),
    .fail     (fail),
    .done     (done),
    .heldWord (heldWord)
  );
endmodule

// File: rtl/chien_locator_chk.sv
module chien_locator_chk
  import chien_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input ctrlStb_t         stb,
  input logic             busy,
  input logic [N-1:0]     heldWord,
  input logic [N-1:0]     corrWord,
  input logic [N-1:0]     errMask,
  input logic [CNT_W-1:0] errCount,
  input logic             fail,
  input logic             done
);
  a_r2_done_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r2_finish_raises_done: assert property (@(posedge clk) disable iff (!rstN)
    stb.finish |=> done);

  a_r5_count_is_popcount: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (errCount == CNT_W'($countones(errMask))));

  a_r4_corrects_held: assert property (@(posedge clk) disable iff (!rstN)
    (done && !fail) |-> (corrWord == (heldWord ^ errMask)));

  a_r6_fail_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (done && fail) |-> (corrWord == heldWord));

  a_r7_no_load_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !stb.load);

  a_r8_hold_results: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finish |=> ($stable(corrWord) && $stable(errMask) && $stable(errCount) && $stable(fail)));
endmodule

bind chien_locator chien_locator_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .stb      (stb),
  .busy     (busy),
  .heldWord (heldWord),
  .corrWord (corrWord),
  .errMask  (errMask),
  .errCount (errCount),
  .fail     (fail),
  .done     (done)
);

// File: tb/chien_locator_test.sv
module chien_locator_test;
  import chien_pkg::*;
  localparam int T = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [(T+1)*4-1:0] lambda = '0;
  logic [14:0] rxWord = '0;
  logic [14:0] corrWord, errMask;
  logic [3:0]  errCount;
  logic        fail, done;

  int nChecks = 0;
  int nFails = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  chien_locator #(.T(T)) uut (
    .clk(clk), .rstN(rstN), .start(start), .lambda(lambda), .rxWord(rxWord),
    .corrWord(corrWord), .errMask(errMask), .errCount(errCount), .fail(fail), .done(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      nFails++;
      $display("FAIL watchdog R2: run did not finish, actual cycles %0d expected below 200000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // GF(16) multiply by schoolbook product and reduction by x^4+x+1
  function automatic logic [3:0] tbMul(logic [3:0] a, logic [3:0] b);
    logic [6:0] p;
    p = '0;
    for (int k = 0; k < 4; k++) if (b[k]) p = p ^ (7'(a) << k);
    for (int k = 6; k >= 4; k--) if (p[k]) p = p ^ (7'(5'b10011) << (k - 4));
    return p[3:0];
  endfunction

  function automatic logic [3:0] tbPow(int e);
    logic [3:0] r;
    r = 4'd1;
    for (int k = 0; k < e; k++) r = tbMul(r, 4'd2);
    return r;
  endfunction

  function automatic logic [3:0] evalAt(logic [15:0] lam, logic [3:0] x);
    logic [3:0] acc;
    acc = '0;
    for (int i = 3; i >= 0; i--) acc = tbMul(acc, x) ^ lam[i*4 +: 4];
    return acc;
  endfunction

  // scale * product over set bits p of (1 + alpha^p x), at most three bits
  function automatic logic [15:0] buildLam(logic [14:0] pos, logic [3:0] scale);
    logic [3:0] c [4];
    logic [3:0] r;
    c[0] = scale; c[1] = '0; c[2] = '0; c[3] = '0;
    for (int p = 0; p < 15; p++) begin
      if (pos[p]) begin
        r = tbPow(p);
        for (int i = 3; i >= 1; i--) c[i] = c[i] ^ tbMul(c[i-1], r);
      end
    end
    return {c[3], c[2], c[1], c[0]};
  endfunction

  function automatic logic [14:0] expMaskOf(logic [15:0] lam);
    logic [14:0] m;
    m = '0;
    for (int p = 0; p < 15; p++) if (evalAt(lam, tbPow((15 - p) % 15)) == 4'd0) m[p] = 1'b1;
    return m;
  endfunction

  function automatic int degOf(logic [15:0] lam);
    int d;
    d = 0;
    for (int i = 1; i <= 3; i++) if (lam[i*4 +: 4] != 4'd0) d = i;
    return d;
  endfunction

  task automatic runOne(input logic [15:0] lam, input logic [14:0] word, input logic [14:0] orig,
                        input bit checkOrig, input bit interrupt, input string maskReq);
    logic [14:0] eMask, eCorr;
    int eCnt;
    bit eFail;
    logic [14:0] hCorr, hMask;
    logic [3:0] hCnt;
    logic hFail;
    eMask = expMaskOf(lam);
    eCnt  = $countones(eMask);
    eFail = (eCnt != degOf(lam));
    eCorr = eFail ? word : (word ^ eMask);
    @(negedge clk);
    lambda = lam; rxWord = word; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rxWord = 15'($urandom);  // R10: inputs change during the search
    lambda = 16'($urandom);
    for (int c = 1; c <= 16; c++) begin
      if (interrupt && c == 4) start = 1'b1;
      if (c == 5) start = 1'b0;
      @(negedge clk);
      if (c == 15) chk("R2", "done early", 32'(done), 32'd0);
    end
    chk("R2", "done at 16th edge", 32'(done), 32'd1);
    chk(maskReq, "errMask", 32'(errMask), 32'(eMask));
    chk("R5", "errCount", 32'(errCount), 32'(eCnt));
    chk("R6", "fail", 32'(fail), 32'(eFail));
    chk(eFail ? "R6" : "R4", "corrWord", 32'(corrWord), 32'(eCorr));
    if (checkOrig) chk("R4", "restored original", 32'(corrWord), 32'(orig));
    hCorr = corrWord; hMask = errMask; hCnt = errCount; hFail = fail;
    @(negedge clk);
    chk("R2", "done one cycle", 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    chk("R8", "hold", {hFail, hCnt, hCorr[5:0]} ^ {fail, errCount, corrWord[5:0]}, 32'd0);
    chk("R8", "hold mask", 32'(errMask), 32'(hMask));
  endtask

  task automatic runErrors(input logic [14:0] pos, input logic [3:0] scale, input bit interrupt, input string req);
    logic [14:0] orig;
    orig = 15'($urandom);
    runOne(buildLam(pos, scale), orig ^ pos, orig, 1'b1, interrupt, req);
  endtask

  initial begin
    logic [15:0] lam;
    logic [14:0] pos;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1", "reset outputs", {17'd0, corrWord} | 32'(errMask) | 32'(errCount) | 32'(fail) | 32'(done), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "after release", {17'd0, corrWord} | 32'(errMask) | 32'(done), 32'd0);

    runErrors(15'h0000, 4'd1, 1'b0, "R3");          // no errors
    runErrors(15'h0001, 4'd1, 1'b0, "R3");          // position 0
    runErrors(15'h4000, 4'd1, 1'b0, "R3");          // position 14
    runErrors(15'h0208, 4'd7, 1'b0, "R9");          // two errors, scaled
    runErrors(15'h4081, 4'd1, 1'b0, "R3");          // three errors at the ends
    runErrors(15'h0422, 4'd11, 1'b1, "R7");         // start during search ignored

    // R6: degree-3 locator with fewer than three roots in the field
    lam = '0;
    for (int t = 0; t < 1000; t++) begin
      lam = {4'($urandom_range(1, 15)), 4'($urandom), 4'($urandom), 4'd1};
      if ($countones(expMaskOf(lam)) < 3) break;
    end
    runOne(lam, 15'($urandom), '0, 1'b0, 1'b0, "R6");

    for (int n = 0; n < 150; n++) begin
      int k;
      k = $urandom_range(0, 3);
      pos = '0;
      while ($countones(pos) < k) pos[$urandom_range(0, 14)] = 1'b1;
      runErrors(pos, 4'($urandom_range(1, 15)), (n % 10) == 3, (n % 2) ? "R9" : "R3");
    end

    for (int n = 0; n < 30; n++) begin
      runOne(16'($urandom), 15'($urandom), '0, 1'b0, 1'b0, "R3");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule